// File: doc/BRIEF.md
# Priority Control-Frame Transmit Selector

This block sits ahead of an Ethernet transmitter and picks the source of the next frame each time the transmitter is idle between frames. There are two sources. One is a single urgent descriptor held inside the block, used for control frames such as pause frames. The other is the normal transmit descriptor queue, reached through a request/grant handshake. The urgent descriptor uses the same fields as a queued descriptor: a status/control word, a byte length and a buffer pointer. Software fills it through a small register write port.

The block looks at the urgent descriptor's ready bit at every frame boundary. If the bit is set, the urgent frame goes out ahead of any queued frame. If it is clear, the next queued frame goes out instead. A frame already on the wire is never cut short.

When the urgent frame finishes, the block clears the ready bit itself, so the frame goes out only once. If the descriptor asked for it, the block also raises a completion event. An urgent descriptor without its last-buffer bit is rejected: the block flags it, clears it and sends nothing for it.

Top module: `txPrioSelect`

## Requirements
- R1: After reset the descriptor is not ready, no frame is in progress and every strobe output (qGrant, frameStart, txDoneEvt, badDescEvt) is low.
- R2: A write with regAddr 0 loads the status word: bit 0 is ready, bit 1 is last-buffer, bit 2 is interrupt-request. regAddr 1 loads the length from bits 15:0. regAddr 2 loads the 32-bit buffer pointer. A write to regAddr 3 changes nothing.
- R3: A frame is launched only in a cycle where txIdle is high and no frame is in progress. A launch is signalled by frameStart high for one cycle, combinationally in that cycle. A frame is in progress from its launch until frameDone is seen.
- R4: At a boundary where the descriptor has both ready and last set, the urgent frame is launched. frameSel is 1, frameLen and framePtr carry the descriptor's length and pointer, and qGrant stays low even when qReq is high.
- R5: At a boundary where the descriptor is not ready and qReq is high, qGrant and frameStart are high in the same cycle, with frameSel 0.
- R6: When an urgent frame completes, its ready bit is cleared, so the next boundary serves the queue.
- R7: txDoneEvt pulses for one cycle, in the cycle frameDone ends an urgent frame, only if that descriptor's interrupt-request bit was set.
- R8: At a boundary where the descriptor is ready but last is clear, badDescEvt pulses for one cycle. No frame starts in that cycle, and the ready bit is cleared.
- R9: frameLen and framePtr keep their launch values for the whole frame, even when the descriptor registers are rewritten during it.
- R10: frameDone while no frame is in progress has no effect and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Descriptor register write strobe |
| regAddr | input | 2 | Register select: 0 status, 1 length, 2 pointer |
| regWrData | input | 32 | Write data |
| qReq | input | 1 | Normal queue has a frame pending |
| qGrant | output | 1 | Queue frame taken at this boundary |
| txIdle | input | 1 | Transmitter is between frames |
| frameDone | input | 1 | Transmitter finished the current frame |
| frameStart | output | 1 | Launch pulse for the next frame |
| frameSel | output | 1 | 1 = urgent descriptor, 0 = queue |
| frameLen | output | 16 | Length of the urgent frame (0 for queue frames) |
| framePtr | output | 32 | Buffer pointer of the urgent frame (0 for queue frames) |
| txDoneEvt | output | 1 | Urgent frame completion event |
| badDescEvt | output | 1 | Urgent descriptor rejected (no last bit) |

## Verification
The bench arms the urgent descriptor while queue requests are pending and checks that the urgent frame wins without a grant. A design with reversed priority would raise qGrant or launch with frameSel 0. It rewrites the length in mid-frame to catch launch values that follow the registers. It then checks that the next boundary goes to the queue, which a design that never clears ready would fail by sending the control frame twice. The remaining cases are:
- A descriptor without the last bit, which must raise the error event with no launch.
- A descriptor without the interrupt bit, which must complete silently.
- Stray frameDone pulses while idle.
- A busy transmitter during which a new launch must not appear.
- A write to the unused address, which must not arm the descriptor.

// File: rtl/txsel_pkg.sv
package txsel_pkg;
  localparam int STAT_RDY_BIT  = 0;
  localparam int STAT_LAST_BIT = 1;
  localparam int STAT_IRQ_BIT  = 2;

  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_LEN  = 2'd1;
  localparam logic [1:0] ADDR_PTR  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_BUSY_PRI = 2'd1,
    ST_BUSY_Q   = 2'd2
  } selState_t;

  typedef struct packed {
    logic launchPri;
    logic launchQ;
    logic clrRdy;
  } selStrobe_t;
endpackage

// File: rtl/txsel_dp.sv
module txsel_dp
  import txsel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  selStrobe_t        strobe,
  output logic              descRdy,
  output logic              descLast,
  output logic              descIrq,
  output logic [LEN_W-1:0]  curLen,
  output logic [PTR_W-1:0]  curPtr
);
  logic [LEN_W-1:0] descLen;
  logic [PTR_W-1:0] descPtr;
  logic wrStat, wrLen, wrPtr;

  assign wrStat = regWrEn && (regAddr == ADDR_STAT);
  assign wrLen  = regWrEn && (regAddr == ADDR_LEN);
  assign wrPtr  = regWrEn && (regAddr == ADDR_PTR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descRdy  <= 1'b0;
      descLast <= 1'b0;
      descIrq  <= 1'b0;
      descLen  <= '0;
      descPtr  <= '0;
    end else begin
      if (wrStat) begin
        descRdy  <= regWrData[STAT_RDY_BIT];
        descLast <= regWrData[STAT_LAST_BIT];
        descIrq  <= regWrData[STAT_IRQ_BIT];
      end else if (strobe.clrRdy) begin
        descRdy <= 1'b0;
      end
      if (wrLen) descLen <= regWrData[LEN_W-1:0];
      if (wrPtr) descPtr <= regWrData[PTR_W-1:0];
    end
  end

  // Launch registers hold the frame parameters for the whole frame.
  logic [LEN_W-1:0] launchLen;
  logic [PTR_W-1:0] launchPtr;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      launchLen <= '0;
      launchPtr <= '0;
    end else if (strobe.launchPri) begin
      launchLen <= descLen;
      launchPtr <= descPtr;
    end else if (strobe.launchQ) begin
      launchLen <= '0;
      launchPtr <= '0;
    end
  end

  // During the launch cycle present the descriptor directly.
  assign curLen = strobe.launchPri ? descLen : (strobe.launchQ ? '0 : launchLen);
  assign curPtr = strobe.launchPri ? descPtr : (strobe.launchQ ? '0 : launchPtr);

  // R6: a hardware clear without a competing status write leaves ready low
  a_r6_rdy_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrRdy && !wrStat) |=> !descRdy);

  // R9: between launches the presented parameters do not move
  a_r9_launch_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.launchPri && !strobe.launchQ && !$past(strobe.launchPri) && !$past(strobe.launchQ))
      |-> $stable(curLen) && $stable(curPtr));
endmodule

// File: rtl/txsel_ctrl.sv
module txsel_ctrl
  import txsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txIdle,
  input  logic       qReq,
  input  logic       frameDone,
  input  logic       descRdy,
  input  logic       descLast,
  input  logic       descIrq,
  output selStrobe_t strobe,
  output logic       qGrant,
  output logic       frameStart,
  output logic       frameSel,
  output logic       txDoneEvt,
  output logic       badDescEvt
);
  selState_t state, stateNxt;
  logic irqLatched;
  logic atBoundary;

  assign atBoundary = (state == ST_IDLE) && txIdle;

  always_comb begin
    strobe     = '0;
    stateNxt   = state;
    badDescEvt = 1'b0;
    txDoneEvt  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (atBoundary) begin
          if (descRdy && descLast) begin
            strobe.launchPri = 1'b1;
            stateNxt         = ST_BUSY_PRI;
          end else if (descRdy) begin
            strobe.clrRdy = 1'b1;
            badDescEvt    = 1'b1;
          end else if (qReq) begin
            strobe.launchQ = 1'b1;
            stateNxt       = ST_BUSY_Q;
          end
        end
      end
      ST_BUSY_PRI: begin
        if (frameDone) begin
          strobe.clrRdy = 1'b1;
          txDoneEvt     = irqLatched;
          stateNxt      = ST_IDLE;
        end
      end
      ST_BUSY_Q: begin
        if (frameDone) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign frameStart = strobe.launchPri || strobe.launchQ;
  assign frameSel   = strobe.launchPri || (state == ST_BUSY_PRI);
  assign qGrant     = strobe.launchQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      irqLatched <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobe.launchPri) irqLatched <= descIrq;
    end
  end

  // R3: launches happen only at an idle boundary
  a_r3_start_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (txIdle && state == ST_IDLE));
  // R3: no second launch while a frame is in flight
  a_r3_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !frameDone) |=> !frameStart);
  // R4: urgent launch never grants the queue
  a_r4_pri_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && frameSel) |-> !qGrant);
  // R5: queue grant coincides with a queue launch
  a_r5_grant_launch: assert property (@(posedge clk) disable iff (!rstN)
    qGrant |-> (frameStart && !frameSel));
  // R7: completion event only on a frameDone
  a_r7_done_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    txDoneEvt |-> frameDone);
  // R8: a rejected descriptor never launches
  a_r8_bad_no_start: assert property (@(posedge clk) disable iff (!rstN)
    badDescEvt |-> !frameStart);
  // R7/R8: event outputs are single-cycle pulses
  a_r8_bad_pulse: assert property (@(posedge clk) disable iff (!rstN)
    badDescEvt |=> !badDescEvt);
endmodule

// File: rtl/txPrioSelect.sv
module txPrioSelect
  import txsel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              qReq,
  output logic              qGrant,
  input  logic              txIdle,
  input  logic              frameDone,
  output logic              frameStart,
  output logic              frameSel,
  output logic [LEN_W-1:0]  frameLen,
  output logic [PTR_W-1:0]  framePtr,
  output logic              txDoneEvt,
  output logic              badDescEvt
);
  selStrobe_t strobe;
  logic descRdy, descLast, descIrq;

  txsel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txIdle(txIdle), .qReq(qReq), .frameDone(frameDone),
    .descRdy(descRdy), .descLast(descLast), .descIrq(descIrq), .strobe(strobe),
    .qGrant(qGrant), .frameStart(frameStart), .frameSel(frameSel),
    .txDoneEvt(txDoneEvt), .badDescEvt(badDescEvt)
  );

  txsel_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .descRdy(descRdy),
    .descLast(descLast), .descIrq(descIrq), .curLen(frameLen), .curPtr(framePtr)
  );
endmodule

// File: tb/txPrioSelect_tb.sv
module txPrioSelect_tb;
  logic clk = 1'b0;
  logic rstN;
  logic regWrEn;
  logic [1:0] regAddr;
  logic [31:0] regWrData;
  logic qReq, txIdle, frameDone;
  logic qGrant, frameStart, frameSel, txDoneEvt, badDescEvt;
  logic [15:0] frameLen;
  logic [31:0] framePtr;
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  txPrioSelect u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .qReq(qReq), .qGrant(qGrant), .txIdle(txIdle),
    .frameDone(frameDone), .frameStart(frameStart), .frameSel(frameSel),
    .frameLen(frameLen), .framePtr(framePtr), .txDoneEvt(txDoneEvt),
    .badDescEvt(badDescEvt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // inputs change on negedge; sample at negedge + 1
  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R1", "frameStart", frameStart, 0);
    chk("R1", "qGrant", qGrant, 0);
    chk("R1", "txDoneEvt", txDoneEvt, 0);
    chk("R1", "badDescEvt", badDescEvt, 0);
    txIdle = 1'b1; #1;
    chk("R1", "no launch, desc not ready", frameStart, 0);
    txIdle = 1'b0;
  endtask

  task automatic tQueue();
    qReq = 1'b1; txIdle = 1'b1; #1;
    chk("R5", "qGrant", qGrant, 1);
    chk("R5", "frameStart", frameStart, 1);
    chk("R5", "frameSel", frameSel, 0);
    step();
    chk("R3", "no launch mid-frame", frameStart, 0);
    chk("R3", "no grant mid-frame", qGrant, 0);
    frameDone = 1'b1; txIdle = 1'b0; qReq = 1'b0;
    step();
    frameDone = 1'b0;
  endtask

  task automatic tPriority();
    wrReg(2'd1, 32'h0000_0040);
    wrReg(2'd2, 32'h0000_1000);
    wrReg(2'd0, 32'h7);
    qReq = 1'b1; txIdle = 1'b1; #1;
    chk("R4", "frameStart", frameStart, 1);
    chk("R4", "frameSel", frameSel, 1);
    chk("R4", "qGrant low", qGrant, 0);
    chk("R4", "frameLen", frameLen, 32'h40);
    chk("R4", "framePtr", framePtr, 32'h1000);
    step();
    txIdle = 1'b0;
    wrReg(2'd1, 32'h0000_0099);
    wrReg(2'd2, 32'h0000_2000);
    chk("R9", "frameLen held", frameLen, 32'h40);
    chk("R9", "framePtr held", framePtr, 32'h1000);
    frameDone = 1'b1; #1;
    chk("R7", "txDoneEvt with irq", txDoneEvt, 1);
    step();
    frameDone = 1'b0; #1;
    chk("R7", "txDoneEvt one cycle", txDoneEvt, 0);
    txIdle = 1'b1; #1;
    chk("R6", "next boundary serves queue", frameSel, 0);
    chk("R6", "queue granted", qGrant, 1);
    step();
    txIdle = 1'b0; qReq = 1'b0; frameDone = 1'b1;
    step();
    frameDone = 1'b0;
  endtask

  task automatic tNoIrq();
    wrReg(2'd0, 32'h3);
    txIdle = 1'b1; #1;
    chk("R4", "urgent launch no irq", frameSel & frameStart, 1);
    step();
    txIdle = 1'b0; frameDone = 1'b1; #1;
    chk("R7", "no txDoneEvt without irq", txDoneEvt, 0);
    step();
    frameDone = 1'b0;
  endtask

  task automatic tBadDesc();
    wrReg(2'd0, 32'h5);
    qReq = 1'b1; txIdle = 1'b1; #1;
    chk("R8", "badDescEvt", badDescEvt, 1);
    chk("R8", "no frameStart", frameStart, 0);
    step();
    chk("R8", "badDescEvt one cycle", badDescEvt, 0);
    chk("R8", "ready cleared, queue served", qGrant, 1);
    step();
    txIdle = 1'b0; qReq = 1'b0; frameDone = 1'b1;
    step();
    frameDone = 1'b0;
  endtask

  task automatic tStrayDone();
    frameDone = 1'b1; txIdle = 1'b0; #1;
    chk("R10", "no txDoneEvt when idle", txDoneEvt, 0);
    step();
    frameDone = 1'b0;
    wrReg(2'd0, 32'h7);
    txIdle = 1'b1; #1;
    chk("R10", "launch unaffected by stray done", frameStart & frameSel, 1);
    step();
    txIdle = 1'b0; frameDone = 1'b1;
    step();
    frameDone = 1'b0;
  endtask

  task automatic tBusyAndAddr3();
    wrReg(2'd3, 32'hFFFF_FFFF);
    txIdle = 1'b1; #1;
    chk("R2", "addr 3 write arms nothing", frameStart, 0);
    txIdle = 1'b0;
    wrReg(2'd0, 32'h3);
    #1;
    chk("R3", "no launch while txIdle low", frameStart, 0);
    step();
    chk("R3", "still no launch while txIdle low", frameStart, 0);
    txIdle = 1'b1; #1;
    chk("R2", "status write arms descriptor", frameStart & frameSel, 1);
    step();
    txIdle = 1'b0; frameDone = 1'b1;
    step();
    frameDone = 1'b0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    qReq = 1'b0; txIdle = 1'b0; frameDone = 1'b0;
    @(negedge clk); step(); step();
    rstN = 1'b1; #1;
    tReset();
    tQueue();
    tPriority();
    tNoIrq();
    tBadDesc();
    tStrayDone();
    tBusyAndAddr3();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule